// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Atomic Set/Clear Access

This block controls 32 general-purpose pins from a small 32-bit register bus. The pins form two banks of 16. Every per-pin control register is changed by a single packed write: a 1 in the low half of the data word turns a pin's bit on, and a 1 in the high half turns it off. Software therefore never needs a read-modify-write sequence, and two agents that own different pins can write the same register without interfering.

Each pin has six writable controls: output value, output enable, input enable, two auxiliary output selects and one auxiliary input select. It also has a synchronized level read-back and two sticky edge-status bits, one for rising and one for falling edges, which are cleared by writing ones. A 4-bit event-map field per pin selects one of eight event pairs and flags power-management events. The block drives the pad output value, the pad output enable and the event-select outputs. Pins 23, 29, 30 and 31 are reserved and hold no state.

Register word index (address bits 6:2): 0 output value, 1 output enable, 2 input enable, 3 aux output A, 4 aux output B, 5 aux input, 6 level read-back, 7 rise status, 8 fall status, 16 to 19 event maps. Address bit 7 selects the high bank (pins 16 to 31), so each high-bank register sits 0x80 above its low-bank partner.

Top module: `gpio_atomic_ctl`

## Requirements
- R1: After reset every control, status and map bit is 0, pad_oe is 0 and evt_sel is 0.
- R2: A write to a control register sets each pin whose bit in wdata[15:0] is 1; pins whose bits are 0 in both halves keep their value.
- R3: A write clears each pin whose bit in wdata[31:16] is 1; when both the set and clear bit of a pin are 1, the pin ends up 0.
- R4: Address bit 7 selects the bank: 0x00 to 0x20 serve pins 0 to 15 and 0x80 to 0xA0 serve pins 16 to 31; a read returns the bank's 16 bits in rdata[15:0] with rdata[31:16] = 0.
- R5: Reserved pins 23, 29, 30 and 31 ignore writes, read as 0 in every register and never drive pad_out, pad_oe or status.
- R6: pad_oe of a pin is 1 only when its output enable is 1 and both its auxiliary output selects are 0; pad_out carries the output-value register.
- R7: The level read-back (word 6) returns pad_in after a two-flop synchronizer.
- R8: A rising change of the synchronized level sets the pin's rise status (word 7) and a falling change sets its fall status (word 8); status stays set until cleared.
- R9: Writing a status register clears each pin whose wdata[15:0] bit is 1; wdata[31:16] and zero bits have no effect.
- R10: Map word 16+k (address 0x40+4k, low bank only) holds pins 8k to 8k+7, pin p at bits 4*(p%8)+3:4*(p%8), written as a whole word; evt_sel[4p+3:4p] shows pin p's field; reserved pins' fields stay 0.
- R11: Read data is registered: bus_rdata updates on the clock edge that samples bus_rd and holds until the next read; unaligned addresses, map words in the high bank and unused words read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data (set half low, clear half high) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Pad driver enable per pin |
| evt_sel | output | 128 | Per-pin event-map fields, 4 bits per pin |

## Verification
Control writes take effect on the clock edge that samples bus_wr, so pad_out and pad_oe are compared at the falling edge right after that write. Read data appears one edge after bus_rd is sampled and the bench reads it at the following falling edge. A pad change reaches the level read-back two edges after it is applied and the edge status on the third; the bench waits four clocks after changing pad_in before reading, so it never samples inside the synchronizer window.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   localparam int NUM_RW = 6;
   localparam int IDX_W  = 5;

   typedef enum logic [IDX_W-1:0] {
      RG_OUT   = 5'd0,
      RG_OE    = 5'd1,
      RG_IE    = 5'd2,
      RG_AUXOA = 5'd3,
      RG_AUXOB = 5'd4,
      RG_AUXI  = 5'd5,
      RG_LVL   = 5'd6,
      RG_RISE  = 5'd7,
      RG_FALL  = 5'd8,
      RG_MAP0  = 5'd16
   } reg_idx_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   // chain[0..STAGES-1]: synchronizer, chain[STAGES]: previous level
   logic [STAGES:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync needs at least two synchronizer stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_in};
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_atomic_pkg::*;
#(
   parameter int              BANK_W         = 16,
   parameter logic [BANK_W-1:0] KEEP_MASK    = '1,
   parameter bit              EDGE_BEATS_CLR = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              reg_idx,
   input  logic [2*BANK_W-1:0]           wdata,
   input  logic [BANK_W-1:0]             rise_evt,
   input  logic [BANK_W-1:0]             fall_evt,
   output logic [NUM_RW-1:0][BANK_W-1:0] feat_q,
   output logic [BANK_W-1:0]             rise_sts,
   output logic [BANK_W-1:0]             fall_sts
);
   logic [BANK_W-1:0] set_v, clr_v;
   logic [BANK_W-1:0] rise_clr, fall_clr, rise_new, fall_new;
   logic [BANK_W-1:0] rise_nxt, fall_nxt;

   assign set_v = wdata[BANK_W-1:0] & KEEP_MASK;
   assign clr_v = wdata[2*BANK_W-1:BANK_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         feat_q <= '0;
      end else if (wr_en) begin
         for (int f = 0; f < NUM_RW; f++) begin
            if (reg_idx == IDX_W'(f)) feat_q[f] <= (feat_q[f] | set_v) & ~clr_v;
         end
      end
   end

   assign rise_clr = (wr_en && reg_idx == RG_RISE) ? set_v : '0;
   assign fall_clr = (wr_en && reg_idx == RG_FALL) ? set_v : '0;
   assign rise_new = rise_evt & KEEP_MASK;
   assign fall_new = fall_evt & KEEP_MASK;

   generate
      if (EDGE_BEATS_CLR) begin : g_edge_first
         assign rise_nxt = (rise_sts & ~rise_clr) | rise_new;
         assign fall_nxt = (fall_sts & ~fall_clr) | fall_new;
      end else begin : g_clr_first
         assign rise_nxt = (rise_sts | rise_new) & ~rise_clr;
         assign fall_nxt = (fall_sts | fall_new) & ~fall_clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_sts <= '0;
         fall_sts <= '0;
      end else begin
         rise_sts <= rise_nxt;
         fall_sts <= fall_nxt;
      end
   end
endmodule

// File: rtl/gpio_evt_map.sv
module gpio_evt_map #(
   parameter int               NPINS     = 32,
   parameter int               MAP_W     = 4,
   parameter int               GRP_PINS  = 8,
   parameter logic [NPINS-1:0] RSVD_MASK = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NPINS/GRP_PINS)-1:0] grp_idx,
   input  logic [GRP_PINS*MAP_W-1:0]     wdata,
   output logic [NPINS*MAP_W-1:0]        map_q
);
   localparam int NGRP  = NPINS / GRP_PINS;
   localparam int GRP_W = GRP_PINS * MAP_W;

   logic [NPINS*MAP_W-1:0] keep_all;

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_keep
         assign keep_all[p*MAP_W +: MAP_W] = RSVD_MASK[p] ? '0 : '1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < NGRP; g++) begin
            if (int'(grp_idx) == g)
               map_q[g*GRP_W +: GRP_W] <= wdata & keep_all[g*GRP_W +: GRP_W];
         end
      end
   end
endmodule

// File: rtl/gpio_atomic_ctl.sv
module gpio_atomic_ctl
   import gpio_atomic_pkg::*;
#(
   parameter int               NPINS          = 32,
   parameter int               BANK_W         = 16,
   parameter int               ADDR_W         = 8,
   parameter int               SYNC_STAGES    = 2,
   parameter int               MAP_W          = 4,
   parameter int               GRP_PINS       = 8,
   parameter logic [NPINS-1:0] RSVD_MASK      = 32'hE080_0000,
   parameter bit               EDGE_BEATS_CLR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic [2*BANK_W-1:0]      bus_wdata,
   input  logic                     bus_rd,
   output logic [2*BANK_W-1:0]      bus_rdata,
   input  logic [NPINS-1:0]         pad_in,
   output logic [NPINS-1:0]         pad_out,
   output logic [NPINS-1:0]         pad_oe,
   output logic [NPINS*MAP_W-1:0]   evt_sel
);
   localparam int DATA_W    = 2 * BANK_W;
   localparam int NBANKS    = NPINS / BANK_W;
   localparam int NGRP      = NPINS / GRP_PINS;
   localparam int GRP_IDX_W = $clog2(NGRP);
   localparam int GRP_W     = GRP_PINS * MAP_W;
   localparam int FIDX_W    = $clog2(NUM_RW);
   localparam logic [NPINS-1:0] KEEP_ALL = ~RSVD_MASK;

   generate
      if (NBANKS != 2 || NBANKS * BANK_W != NPINS) begin : g_bad_banks
         $error("gpio_atomic_ctl expects exactly two equal banks");
      end
      if (ADDR_W != 8) begin : g_bad_addr
         $error("gpio_atomic_ctl decodes an 8-bit byte address");
      end
      if (GRP_W != DATA_W || NGRP * GRP_PINS != NPINS) begin : g_bad_map
         $error("event-map groups must fill one data word each");
      end
   endgenerate

   // address decode
   logic              aligned, bank_sel, map_hit;
   logic [IDX_W-1:0]  reg_idx;
   logic [GRP_IDX_W-1:0] grp_idx;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign bank_sel = bus_addr[ADDR_W-1];
   assign reg_idx  = bus_addr[ADDR_W-2:2];
   assign map_hit  = aligned && !bank_sel &&
                     (reg_idx >= RG_MAP0) && (reg_idx < IDX_W'(int'(RG_MAP0) + NGRP));
   assign grp_idx  = GRP_IDX_W'(reg_idx - RG_MAP0);

   // per-bank state
   logic [NBANKS-1:0][NUM_RW-1:0][BANK_W-1:0] feat_all;
   logic [NPINS-1:0] lvl_all, rise_evt, fall_evt;
   logic [NPINS-1:0] rise_sts_all, fall_sts_all;

   gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pad_in),
      .lvl    (lvl_all),
      .rise   (rise_evt),
      .fall   (fall_evt)
   );

   generate
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         logic bank_wr;
         assign bank_wr = bus_wr && aligned && (int'(bank_sel) == b);

         gpio_bank_regs #(
            .BANK_W         (BANK_W),
            .KEEP_MASK      (KEEP_ALL[b*BANK_W +: BANK_W]),
            .EDGE_BEATS_CLR (EDGE_BEATS_CLR)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .reg_idx  (reg_idx),
            .wdata    (bus_wdata),
            .rise_evt (rise_evt[b*BANK_W +: BANK_W]),
            .fall_evt (fall_evt[b*BANK_W +: BANK_W]),
            .feat_q   (feat_all[b]),
            .rise_sts (rise_sts_all[b*BANK_W +: BANK_W]),
            .fall_sts (fall_sts_all[b*BANK_W +: BANK_W])
         );

         assign pad_out[b*BANK_W +: BANK_W] = feat_all[b][RG_OUT];
         assign pad_oe[b*BANK_W +: BANK_W]  = feat_all[b][RG_OE] &
                                              ~feat_all[b][RG_AUXOA] &
                                              ~feat_all[b][RG_AUXOB];
      end
   endgenerate

   gpio_evt_map #(
      .NPINS     (NPINS),
      .MAP_W     (MAP_W),
      .GRP_PINS  (GRP_PINS),
      .RSVD_MASK (RSVD_MASK)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && map_hit),
      .grp_idx (grp_idx),
      .wdata   (bus_wdata),
      .map_q   (evt_sel)
   );

   // read path
   logic [NPINS-1:0]  lvl_kept;
   logic [BANK_W-1:0] bank_lvl, bank_rise, bank_fall;
   logic [DATA_W-1:0] rd_next;

   assign lvl_kept  = lvl_all & KEEP_ALL;
   assign bank_lvl  = bank_sel ? lvl_kept[BANK_W +: BANK_W]     : lvl_kept[0 +: BANK_W];
   assign bank_rise = bank_sel ? rise_sts_all[BANK_W +: BANK_W] : rise_sts_all[0 +: BANK_W];
   assign bank_fall = bank_sel ? fall_sts_all[BANK_W +: BANK_W] : fall_sts_all[0 +: BANK_W];

   always_comb begin
      rd_next = '0;
      if (map_hit) begin
         rd_next = evt_sel[grp_idx*GRP_W +: GRP_W];
      end else if (aligned) begin
         if (reg_idx < IDX_W'(NUM_RW))
            rd_next = {{BANK_W{1'b0}}, feat_all[bank_sel][reg_idx[FIDX_W-1:0]]};
         else if (reg_idx == RG_LVL)
            rd_next = {{BANK_W{1'b0}}, bank_lvl};
         else if (reg_idx == RG_RISE)
            rd_next = {{BANK_W{1'b0}}, bank_rise};
         else if (reg_idx == RG_FALL)
            rd_next = {{BANK_W{1'b0}}, bank_fall};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/gpio_atomic_chk.sv
module gpio_atomic_chk #(
   parameter int               NPINS     = 32,
   parameter logic [NPINS-1:0] RSVD_MASK = 32'hE080_0000
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       bus_addr,
   input logic             bus_wr,
   input logic [31:0]      bus_wdata,
   input logic             bus_rd,
   input logic [31:0]      bus_rdata,
   input logic [NPINS-1:0] pad_out,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] rise_sts,
   input logic [NPINS-1:0] fall_sts
);
   a_r2_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h00 && bus_wdata[0] && !bus_wdata[16]) |=> pad_out[0]);

   a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h00 && bus_wdata[16]) |=> !pad_out[0]);

   a_r5_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out | pad_oe | rise_sts | fall_sts) & RSVD_MASK) == '0);

   a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h04 && bus_wdata[16]) |=> !pad_oe[0]);

   a_r8_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ((($past(rise_sts) & ~rise_sts) == '0) &&
                   (($past(fall_sts) & ~fall_sts) == '0)));

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_atomic_ctl gpio_atomic_chk #(
   .NPINS     (NPINS),
   .RSVD_MASK (RSVD_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .rise_sts  (rise_sts_all),
   .fall_sts  (fall_sts_all)
);

// File: tb/test_gpio_atomic_ctl.sv
module test_gpio_atomic_ctl;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic         bus_wr = 1'b0;
   logic [31:0]  bus_wdata = '0;
   logic         bus_rd = 1'b0;
   logic [31:0]  bus_rdata;
   logic [31:0]  pad_in = '0;
   logic [31:0]  pad_out;
   logic [31:0]  pad_oe;
   logic [127:0] evt_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_atomic_ctl i_gpio_atomic_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .evt_sel   (evt_sel)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(tag, d, exp);
   endtask

   task automatic wait_clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 pad_oe after reset", pad_oe, 32'h0);
      check("R1 evt_sel low after reset", evt_sel[31:0], 32'h0);
      read_check("R1 output value after reset", 8'h00, 32'h0);
      read_check("R1 high rise status after reset", 8'h9C, 32'h0);
   endtask

   task automatic t_set_clear;
      bus_write(8'h00, 32'h0000_00A5);
      read_check("R2 set pattern", 8'h00, 32'h0000_00A5);
      bus_write(8'h00, 32'h0000_0100);
      read_check("R2 zero bits keep value", 8'h00, 32'h0000_01A5);
      bus_write(8'h00, 32'h0001_0000);
      read_check("R3 clear half", 8'h00, 32'h0000_01A4);
      bus_write(8'h00, 32'h0004_0004);
      read_check("R3 clear beats set", 8'h00, 32'h0000_01A0);
   endtask

   task automatic t_high_bank;
      bus_write(8'h80, 32'h0000_FFFF);
      read_check("R4 R5 high bank set, reserved masked", 8'h80, 32'h0000_1F7F);
      read_check("R4 low bank untouched", 8'h00, 32'h0000_01A0);
      check("R4 pad_out both banks", pad_out, 32'h1F7F_01A0);
   endtask

   task automatic t_oe;
      bus_write(8'h04, 32'h0000_0003);
      bus_write(8'h0C, 32'h0000_0002);
      bus_write(8'h90, 32'h0000_0001);
      bus_write(8'h84, 32'h0000_0003);
      check("R6 pad_oe gated by aux selects", pad_oe, 32'h0002_0001);
      bus_write(8'h0C, 32'h0002_0000);
      check("R6 aux cleared re-enables pin1", pad_oe, 32'h0002_0003);
   endtask

   task automatic t_edges;
      @(negedge clk);
      pad_in = 32'h8001_8001;
      wait_clks(4);
      read_check("R7 low level", 8'h18, 32'h0000_8001);
      read_check("R7 R5 high level reserved masked", 8'h98, 32'h0000_0001);
      read_check("R8 low rise", 8'h1C, 32'h0000_8001);
      read_check("R8 R5 high rise", 8'h9C, 32'h0000_0001);
      read_check("R8 no fall yet", 8'h20, 32'h0);
      @(negedge clk);
      pad_in = 32'h0;
      wait_clks(4);
      read_check("R8 low fall", 8'h20, 32'h0000_8001);
      read_check("R8 rise sticky", 8'h1C, 32'h0000_8001);
   endtask

   task automatic t_w1c;
      bus_write(8'h1C, 32'hFFFF_0001);
      read_check("R9 one clears, high half ignored", 8'h1C, 32'h0000_8000);
      bus_write(8'h20, 32'h0);
      read_check("R9 zero write no effect", 8'h20, 32'h0000_8001);
      bus_write(8'h9C, 32'h0000_0001);
      read_check("R9 high bank clear", 8'h9C, 32'h0);
   endtask

   task automatic t_map;
      bus_write(8'h40, 32'h8765_4321);
      check("R10 evt_sel group 0", evt_sel[31:0], 32'h8765_4321);
      read_check("R10 map read", 8'h40, 32'h8765_4321);
      bus_write(8'h48, 32'hFFFF_FFFF);
      read_check("R10 pin 23 field reserved", 8'h48, 32'h0FFF_FFFF);
      check("R10 evt_sel group 2", evt_sel[95:64], 32'h0FFF_FFFF);
      bus_write(8'h4C, 32'hFFFF_FFFF);
      check("R10 evt_sel group 3", evt_sel[127:96], 32'h000F_FFFF);
      bus_write(8'hC0, 32'h1111_1111);
      read_check("R11 high-bank map alias ignored", 8'h40, 32'h8765_4321);
      read_check("R11 high-bank map alias reads 0", 8'hC0, 32'h0);
   endtask

   task automatic t_read_path;
      bus_write(8'h01, 32'h0000_FFFF);
      read_check("R11 unaligned write ignored", 8'h00, 32'h0000_01A0);
      read_check("R11 unaligned read 0", 8'h02, 32'h0);
      read_check("R11 unused word reads 0", 8'h34, 32'h0);
      read_check("R11 read before hold", 8'h80, 32'h0000_1F7F);
      @(negedge clk);
      bus_addr = 8'h00;
      wait_clks(3);
      check("R11 rdata held without read", bus_rdata, 32'h0000_1F7F);
   endtask

   initial begin
      wait_clks(3);
      rst_n = 1'b1;
      wait_clks(1);
      t_reset();
      t_set_clear();
      t_high_bank();
      t_oe();
      t_edges();
      t_w1c();
      t_map();
      t_read_path();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule